// File: doc/BRIEF.md
# Fixed-Coefficient Linear Evaluator (three times A less two times B)

This block is a purely combinational datapath that evaluates the expression 3A - 2B on two unsigned operands, 16 bits wide by default. It has no arithmetic operators and no shifts. The expression is assembled from ripple adder stages built out of AND, OR and inversion. A first stage doubles A by adding it to itself. A second stage adds A again to reach 3A. A third stage doubles B the same way. A final adder-subtractor stage, held in subtract mode, forms the difference.

Every stage can leave the unsigned range. Each doubling or tripling stage reports a carry out of its top bit. The subtraction reports a borrow when 3A is smaller than 2B. These four indications are ORed into a single error output. The result bus always carries the low bits of the true value, that is, the value modulo 2^W, whether or not the error output is set. A consumer that needs an exact answer treats the result as valid only when the error output is low.

Top module: `lin3a2b`

## Requirements
- R1: `res_o` always equals (3·A − 2·B) modulo 2^W, for every pair of operands.
- R2: When doubling A does not fit in W bits (A ≥ 2^(W−1)), `err_o` is 1.
- R3: When 3·A exceeds 2^W − 1, `err_o` is 1, including operands for which 2·A still fits (for W=16, A=21846 gives result 2 with error, while A=21845 and B=0 give 65535 without error).
- R4: When doubling B does not fit in W bits (B ≥ 2^(W−1)), `err_o` is 1.
- R5: When 3·A and 2·B both fit in W bits but 3·A < 2·B (a negative result), `err_o` is 1.
- R6: When 3·A ≤ 2^W − 1, 2·B ≤ 2^W − 1 and 3·A ≥ 2·B, `err_o` is 0. Examples: A=202, B=97 gives 412, and A=44, B=9 gives 114.
- R7: When 3·A equals 2·B exactly (for example A=2, B=3), `res_o` is 0 and `err_o` is 0. The borrow boundary does not raise the flag.
- R8: The block holds no state. `res_o` and `err_o` follow a change of the operands without any clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | W (16) | Unsigned operand A |
| b_i | input | W (16) | Unsigned operand B |
| res_o | output | W (16) | Low W bits of 3A − 2B |
| err_o | output | 1 | Set when any stage leaves the unsigned range or the result is negative |

## Verification
The hardest case to reach is an error raised by the tripling carry alone. This needs A between 21846 and 32767, so that 2A still fits but 3A does not. Operand patterns spread evenly over the input space reach this window only rarely. A second hard case is the exact zero boundary 3A = 2B. For that reason, the vector table places operands on both sides of the tripling and doubling limits and on the 3A = 2B line. A walked operand sweep then covers the remaining combinations of stage flags, and each expected value is computed independently in the bench.

// File: rtl/lin3a2b_pkg.sv
package lin3a2b_pkg;
  parameter int unsigned OPW = 16;

  typedef enum logic {
    MODE_ADD = 1'b0,
    MODE_SUB = 1'b1
  } arith_mode_e;
endpackage

// File: rtl/bit_fa.sv
module bit_fa (
  input  logic x_i,
  input  logic y_i,
  input  logic c_i,
  output logic s_o,
  output logic c_o
);
  logic hx;
  logic hc;
  logic tc;

  // first half adder
  assign hx = (x_i & ~y_i) | (~x_i & y_i);
  assign hc = x_i & y_i;
  // second half adder
  assign s_o = (hx & ~c_i) | (~hx & c_i);
  assign tc  = hx & c_i;
  assign c_o = hc | tc;
endmodule

// File: rtl/ripple_add.sv
module ripple_add #(
  parameter int unsigned W = 16
) (
  input  logic [W-1:0] x_i,
  input  logic [W-1:0] y_i,
  input  logic         cin_i,
  output logic [W-1:0] sum_o,
  output logic         cout_o
);
  logic [W:0] chain;

  assign chain[0] = cin_i;

  for (genvar k = 0; k < W; k++) begin : g_bit
    bit_fa u_fa (
      .x_i (x_i[k]),
      .y_i (y_i[k]),
      .c_i (chain[k]),
      .s_o (sum_o[k]),
      .c_o (chain[k+1])
    );
  end

  assign cout_o = chain[W];
endmodule

// File: rtl/addsub.sv
module addsub
  import lin3a2b_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic [W-1:0] x_i,
  input  logic [W-1:0] y_i,
  input  arith_mode_e  mode_i,
  output logic [W-1:0] res_o,
  output logic         range_o
);
  logic         sub;
  logic [W-1:0] y_eff;
  logic         co;

  assign sub = (mode_i == MODE_SUB);

  // conditional inversion of the second operand
  for (genvar k = 0; k < W; k++) begin : g_inv
    assign y_eff[k] = (y_i[k] & ~sub) | (~y_i[k] & sub);
  end

  ripple_add #(.W(W)) u_add (
    .x_i    (x_i),
    .y_i    (y_eff),
    .cin_i  (sub),
    .sum_o  (res_o),
    .cout_o (co)
  );

  // add: carry out means overflow; subtract: missing carry means borrow
  assign range_o = (co & ~sub) | (~co & sub);
endmodule

// File: rtl/lin3a2b.sv
module lin3a2b
  import lin3a2b_pkg::*;
#(
  parameter int unsigned W = OPW
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] res_o,
  output logic         err_o
);
  logic [W-1:0] a_x2;
  logic [W-1:0] a_x3;
  logic [W-1:0] b_x2;
  logic         cy_a2;
  logic         cy_a3;
  logic         cy_b2;
  logic         brw;

  // stage 1: A doubled
  ripple_add #(.W(W)) u_dbl_a (
    .x_i    (a_i),
    .y_i    (a_i),
    .cin_i  (1'b0),
    .sum_o  (a_x2),
    .cout_o (cy_a2)
  );

  // stage 2: A tripled
  ripple_add #(.W(W)) u_tri_a (
    .x_i    (a_x2),
    .y_i    (a_i),
    .cin_i  (1'b0),
    .sum_o  (a_x3),
    .cout_o (cy_a3)
  );

  // stage 3: B doubled
  ripple_add #(.W(W)) u_dbl_b (
    .x_i    (b_i),
    .y_i    (b_i),
    .cin_i  (1'b0),
    .sum_o  (b_x2),
    .cout_o (cy_b2)
  );

  // stage 4: difference
  addsub #(.W(W)) u_diff (
    .x_i     (a_x3),
    .y_i     (b_x2),
    .mode_i  (MODE_SUB),
    .res_o   (res_o),
    .range_o (brw)
  );

  assign err_o = cy_a2 | cy_a3 | cy_b2 | brw;
endmodule

// File: rtl/lin3a2b_chk.sv
module lin3a2b_chk #(
  parameter int unsigned W = 16
) (
  input logic [W-1:0] a_i,
  input logic [W-1:0] b_i,
  input logic [W-1:0] res_o,
  input logic         err_o
);
  longint       a3;
  longint       b2;
  longint       lim;
  logic [W-1:0] want;

  always_comb begin
    a3   = 3 * longint'(a_i);
    b2   = 2 * longint'(b_i);
    lim  = longint'(1) << W;
    want = W'(a3 - b2);
    if (!$isunknown({a_i, b_i, res_o, err_o})) begin
      p_result_mod_r1: assert (res_o == want)
        else $error("R1 result mismatch");
      if (a_i[W-1])
        p_err_double_a_r2: assert (err_o) else $error("R2 flag missing");
      if (a3 >= lim)
        p_err_triple_a_r3: assert (err_o) else $error("R3 flag missing");
      if (b_i[W-1])
        p_err_double_b_r4: assert (err_o) else $error("R4 flag missing");
      if (a3 < lim && b2 < lim && a3 < b2)
        p_err_negative_r5: assert (err_o) else $error("R5 flag missing");
      if (a3 < lim && b2 < lim && a3 >= b2)
        p_no_err_r6: assert (!err_o) else $error("R6 spurious flag");
      if (a3 == b2 && a3 < lim)
        p_zero_edge_r7: assert (res_o == '0 && !err_o) else $error("R7 boundary");
    end
  end
endmodule

bind lin3a2b lin3a2b_chk #(.W(W)) u_chk (
  .a_i   (a_i),
  .b_i   (b_i),
  .res_o (res_o),
  .err_o (err_o)
);

// File: tb/lin3a2b_tb.sv
module lin3a2b_tb;
  localparam int W = 16;
  localparam int NV = 16;
  localparam int WDOG = 50000;

  typedef struct packed {
    logic [15:0] a;
    logic [15:0] b;
    logic [15:0] r;
    logic        e;
  } vec_t;

  localparam vec_t VT [NV] = '{
    '{16'd3105,  16'd11275, 16'd52301, 1'b1}, // R5
    '{16'd21,    16'd83,    16'd65433, 1'b1}, // R5
    '{16'd24,    16'd32,    16'd8,     1'b0}, // R6
    '{16'd16386, 16'd353,   16'd48452, 1'b0}, // R6
    '{16'd202,   16'd97,    16'd412,   1'b0}, // R6
    '{16'd44,    16'd9,     16'd114,   1'b0}, // R6
    '{16'd64,    16'd65535, 16'd194,   1'b1}, // R4
    '{16'd8,     16'd52,    16'd65456, 1'b1}, // R5
    '{16'd21846, 16'd0,     16'd2,     1'b1}, // R3
    '{16'd21845, 16'd0,     16'd65535, 1'b0}, // R3 edge
    '{16'd32768, 16'd0,     16'd32768, 1'b1}, // R2
    '{16'd0,     16'd32768, 16'd0,     1'b1}, // R4
    '{16'd2,     16'd3,     16'd0,     1'b0}, // R7
    '{16'd21845, 16'd32767, 16'd1,     1'b0}, // R6 edge
    '{16'd0,     16'd1,     16'd65534, 1'b1}, // R5
    '{16'd65535, 16'd65535, 16'd65535, 1'b1}  // R2
  };

  logic         clk;
  logic         rst_n;
  logic [W-1:0] a_i;
  logic [W-1:0] b_i;
  logic [W-1:0] res_o;
  logic         err_o;
  int           n_chk;
  int           n_fail;
  logic         done;

  lin3a2b u_dut (
    .a_i   (a_i),
    .b_i   (b_i),
    .res_o (res_o),
    .err_o (err_o)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(input string req, input logic [W-1:0] er, input logic ee);
    n_chk++;
    if (res_o !== er || err_o !== ee) begin
      n_fail++;
      $display("FAIL %s a=%0d b=%0d: res=%0d err=%0b expected res=%0d err=%0b",
               req, a_i, b_i, res_o, err_o, er, ee);
    end
  endtask

  task automatic apply(input logic [W-1:0] a, input logic [W-1:0] b);
    @(negedge clk);
    a_i = a;
    b_i = b;
    #1;
  endtask

  function automatic logic [W:0] model(input logic [W-1:0] a, input logic [W-1:0] b);
    longint t3, t2;
    logic   e;
    t3 = 3 * longint'(a);
    t2 = 2 * longint'(b);
    e  = (t3 > 65535) || (t2 > 65535) || (t3 < t2);
    return {e, W'(t3 - t2)};
  endfunction

  initial begin
    done = 1'b0;
    repeat (WDOG) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [W:0]   m;
    logic [W-1:0] sa;
    logic [W-1:0] sb;
    n_chk  = 0;
    n_fail = 0;
    rst_n  = 1'b0;
    a_i    = '0;
    b_i    = '0;
    repeat (3) @(posedge clk);
    #1;
    check("R1 idle zero operands", '0, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      apply(VT[i].a, VT[i].b);
      check("R1-table", VT[i].r, VT[i].e);
    end

    // R8: outputs follow operands with no clock edge in between
    @(posedge clk);
    #0.5;
    a_i = 16'd202;
    b_i = 16'd97;
    #0.5;
    check("R8 no-clock update", 16'd412, 1'b0);
    a_i = 16'd0;
    b_i = 16'd1;
    #0.5;
    check("R8 no-clock update", 16'd65534, 1'b1);

    // R3: tripling carry window with 2A still in range
    for (int k = 0; k < 8; k++) begin
      sa = 16'(21846 + k * 1400);
      apply(sa, 16'd5);
      m = model(sa, 16'd5);
      check("R3 triple window", m[W-1:0], m[W]);
    end

    // R7: exact 3A == 2B line
    for (int k = 0; k < 8; k++) begin
      sa = 16'(2 * (k * 1000 + 1));
      sb = 16'(3 * (k * 1000 + 1));
      apply(sa, sb);
      check("R7 zero line", '0, 1'b0);
    end

    // R1 R2 R4 R5 R6: walked sweep
    sa = 16'hACE1;
    sb = 16'h1234;
    for (int k = 0; k < 600; k++) begin
      sa = {sa[14:0], sa[15] ^ sa[13] ^ sa[12] ^ sa[10]};
      sb = sb * 16'd25173 + 16'd13849;
      apply(sa >> (k % 4), sb >> ((k / 4) % 4));
      m = model(a_i, b_i);
      check("R1 R2 R4 R5 R6 sweep", m[W-1:0], m[W]);
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule